// File: doc/BRIEF.md
# Run-Time Reshapeable Dual-Clock RAM

A simple dual-port memory of fixed bit capacity whose word shape is chosen at run time by a 2-bit shape input. With the default parameters the array holds 1,152 bits and can be viewed as 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. The write side and the read side each have their own clock. The address bus is always 9 bits wide and the data buses are always 18 bits wide. In a narrow shape only the low lines of each bus take part.

Every word maps to a run of bits in one flat store, starting at bit offset `address x width`. Data written under one shape can therefore be read back under another, and the reader sees the same bits cut differently. The two narrowest shapes reach only the lower 1,024 bits.

The read side works in one of two styles, picked by `flow_sel`. In the clocked style a read register loads on a read-clock edge while `rd_en` is high. In the flow-through style the addressed word passes straight to the output while `rd_en` is high. Otherwise the output shows the value the read register last loaded. The output stage has two named states. `OUT_HELD` drives the read register, and `OUT_LIVE` drives the combinational word. The design moves from `OUT_HELD` to `OUT_LIVE` when `flow_sel` and `rd_en` are both high, and back on every other input combination. The shape decoder has four named states: `SHP_64X18`, `SHP_128X9`, `SHP_256X4` and `SHP_512X2`.

Top module: `aspect_ram`

## Requirements
- R1: `shape` encodes 00=64x18, 01=128x9, 10=256x4 and 11=512x2. A word occupies the low 18, 9, 4 or 2 data lines and is addressed by the low 6, 7, 8 or 9 address lines.
- R2: A word is stored on a rising `wr_clk` edge only when `wr_en` is high. With `wr_en` low, the addressed word keeps its old contents.
- R3: Address lines above the active address width are ignored on both ports.
- R4: `wr_data` lines above the active data width are ignored.
- R5: With `flow_sel`=0, `rd_data` takes the addressed word on a rising `rd_clk` edge when `rd_en` is high, and holds its value when `rd_en` is low.
- R6: With `flow_sel`=1 and `rd_en`=1, `rd_data` follows the addressed word combinationally, including a word that a write has just changed.
- R7: With `flow_sel`=1 and `rd_en`=0, `rd_data` shows the word loaded at the last `rd_clk` edge on which `rd_en` was high, even if that word is later overwritten.
- R8: `rd_data` bits above the active data width read as zero.
- R9: A clocked read and a write to the same address on the same edge of a shared clock return the old word.
- R10: `rd_rst_n` low clears the read register to zero, so a clocked read shows zero.
- R11: The bits of word `a` start at bit offset `a x width` of one shared store, so a word written under one shape is seen as its bit slices under another shape.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| wr_en | input | 1 | Write enable, acts as a clock enable |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low bits active |
| shape | input | 2 | Word shape select |
| rd_clk | input | 1 | Read clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read register |
| rd_en | input | 1 | Read enable; a clock enable or a flow-through gate |
| flow_sel | input | 1 | 1 selects flow-through read, 0 selects clocked read |
| rd_addr | input | 9 | Read word address |
| rd_data | output | 18 | Read data, unused upper bits zero |

## Verification
A write becomes visible one `wr_clk` edge after the inputs are set up. A clocked read result appears at the first `rd_clk` edge after `rd_en` and the address are applied. The bench drives each stimulus at a falling edge and samples at the next falling edge. A flow-through result is due within the same cycle, so the bench samples it one nanosecond after changing the read address. Hold behaviour is checked only after at least one rising edge has passed with `rd_en` low. This shows that no edge changed the output.

// File: rtl/ram_shape_pkg.sv
package ram_shape_pkg;

    typedef enum logic [1:0] {
        SHP_64X18 = 2'b00,
        SHP_128X9 = 2'b01,
        SHP_256X4 = 2'b10,
        SHP_512X2 = 2'b11
    } shape_e;

    typedef enum logic {
        OUT_HELD = 1'b0,
        OUT_LIVE = 1'b1
    } out_sel_e;

endpackage

// File: rtl/aspect_ram_decode.sv
module aspect_ram_decode
    import ram_shape_pkg::*;
#(
    parameter int WORD_W    = 18,
    parameter int MIN_ABITS = 6,
    parameter int ADDR_W    = MIN_ABITS + 3,
    parameter int OFS_W     = $clog2(WORD_W << MIN_ABITS),
    parameter int WID_W     = $clog2(WORD_W + 1)
) (
    input  logic [1:0]        shape,
    input  logic [ADDR_W-1:0] addr,
    output logic [OFS_W-1:0]  base,
    output logic [WID_W-1:0]  width
);

    int unsigned       keep_bits;
    logic [ADDR_W-1:0] addr_keep;

    always_comb begin
        unique case (shape_e'(shape))
            SHP_64X18: begin width = WID_W'(WORD_W);      keep_bits = MIN_ABITS;     end
            SHP_128X9: begin width = WID_W'(WORD_W >> 1); keep_bits = MIN_ABITS + 1; end
            SHP_256X4: begin width = WID_W'(WORD_W >> 2); keep_bits = MIN_ABITS + 2; end
            SHP_512X2: begin width = WID_W'(WORD_W >> 3); keep_bits = MIN_ABITS + 3; end
            default:   begin width = WID_W'(WORD_W);      keep_bits = MIN_ABITS;     end
        endcase
        addr_keep = addr & ADDR_W'((1 << keep_bits) - 1);
        base      = OFS_W'(addr_keep) * OFS_W'(width);
    end

endmodule

// File: rtl/aspect_ram_store.sv
module aspect_ram_store #(
    parameter int WORD_W    = 18,
    parameter int MIN_ABITS = 6,
    parameter int CAP_BITS  = WORD_W << MIN_ABITS,
    parameter int OFS_W     = $clog2(CAP_BITS),
    parameter int WID_W     = $clog2(WORD_W + 1)
) (
    input  logic                wr_clk,
    input  logic                wr_en,
    input  logic [OFS_W-1:0]    base,
    input  logic [WID_W-1:0]    width,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [CAP_BITS-1:0] cells
);

    logic [OFS_W-1:0] lane_idx [WORD_W];
    logic             lane_on  [WORD_W];

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        assign lane_idx[g] = base + OFS_W'(g);
        assign lane_on[g]  = wr_en && (WID_W'(g) < width);
    end

    always_ff @(posedge wr_clk) begin
        for (int i = 0; i < WORD_W; i++) begin
            if (lane_on[i]) cells[lane_idx[i]] <= wr_data[i];
        end
    end

endmodule

// File: rtl/aspect_ram_extract.sv
module aspect_ram_extract #(
    parameter int WORD_W    = 18,
    parameter int MIN_ABITS = 6,
    parameter int CAP_BITS  = WORD_W << MIN_ABITS,
    parameter int OFS_W     = $clog2(CAP_BITS),
    parameter int WID_W     = $clog2(WORD_W + 1)
) (
    input  logic [CAP_BITS-1:0] cells,
    input  logic [OFS_W-1:0]    base,
    input  logic [WID_W-1:0]    width,
    output logic [WORD_W-1:0]   word
);

    for (genvar g = 0; g < WORD_W; g++) begin : g_lane
        logic [OFS_W-1:0] idx;
        assign idx     = base + OFS_W'(g);
        assign word[g] = (WID_W'(g) < width) ? cells[idx] : 1'b0;
    end

endmodule

// File: rtl/aspect_ram_rdport.sv
module aspect_ram_rdport
    import ram_shape_pkg::*;
#(
    parameter int WORD_W = 18
) (
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    input  logic              flow_sel,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] held_q;
    out_sel_e          out_sel;

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)  held_q <= '0;
        else if (rd_en) held_q <= word_in;
    end

    always_comb begin
        out_sel = (flow_sel && rd_en) ? OUT_LIVE : OUT_HELD;
    end

    always_comb begin
        unique case (out_sel)
            OUT_LIVE: rd_data = word_in;
            OUT_HELD: rd_data = held_q;
            default:  rd_data = held_q;
        endcase
    end

endmodule

// File: rtl/aspect_ram.sv
module aspect_ram #(
    parameter int WORD_W    = 18,
    parameter int MIN_ABITS = 6
) (
    input  logic                     wr_clk,
    input  logic                     wr_en,
    input  logic [MIN_ABITS+2:0]     wr_addr,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [1:0]               shape,
    input  logic                     rd_clk,
    input  logic                     rd_rst_n,
    input  logic                     rd_en,
    input  logic                     flow_sel,
    input  logic [MIN_ABITS+2:0]     rd_addr,
    output logic [WORD_W-1:0]        rd_data
);

    localparam int ADDR_W   = MIN_ABITS + 3;
    localparam int CAP_BITS = WORD_W << MIN_ABITS;
    localparam int OFS_W    = $clog2(CAP_BITS);
    localparam int WID_W    = $clog2(WORD_W + 1);

    logic [OFS_W-1:0]    wr_base, rd_base;
    logic [WID_W-1:0]    wr_width, rd_width;
    logic [CAP_BITS-1:0] cells;
    logic [WORD_W-1:0]   rd_word;

    aspect_ram_decode #(.WORD_W(WORD_W), .MIN_ABITS(MIN_ABITS), .ADDR_W(ADDR_W),
                        .OFS_W(OFS_W), .WID_W(WID_W)) u_wr_dec (
        .shape(shape), .addr(wr_addr), .base(wr_base), .width(wr_width)
    );

    aspect_ram_decode #(.WORD_W(WORD_W), .MIN_ABITS(MIN_ABITS), .ADDR_W(ADDR_W),
                        .OFS_W(OFS_W), .WID_W(WID_W)) u_rd_dec (
        .shape(shape), .addr(rd_addr), .base(rd_base), .width(rd_width)
    );

    aspect_ram_store #(.WORD_W(WORD_W), .MIN_ABITS(MIN_ABITS), .CAP_BITS(CAP_BITS),
                       .OFS_W(OFS_W), .WID_W(WID_W)) u_store (
        .wr_clk(wr_clk), .wr_en(wr_en), .base(wr_base), .width(wr_width),
        .wr_data(wr_data), .cells(cells)
    );

    aspect_ram_extract #(.WORD_W(WORD_W), .MIN_ABITS(MIN_ABITS), .CAP_BITS(CAP_BITS),
                         .OFS_W(OFS_W), .WID_W(WID_W)) u_extract (
        .cells(cells), .base(rd_base), .width(rd_width), .word(rd_word)
    );

    aspect_ram_rdport #(.WORD_W(WORD_W)) u_rdport (
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .flow_sel(flow_sel),
        .word_in(rd_word), .rd_data(rd_data)
    );

endmodule

// File: rtl/aspect_ram_chk.sv
module aspect_ram_chk #(
    parameter int WORD_W    = 18,
    parameter int MIN_ABITS = 6
) (
    input logic                 wr_clk,
    input logic                 wr_en,
    input logic [1:0]           shape,
    input logic                 rd_clk,
    input logic                 rd_rst_n,
    input logic                 rd_en,
    input logic                 flow_sel,
    input logic [WORD_W-1:0]    rd_data
);

    AST_SHAPE_KNOWN: assert property (@(posedge wr_clk)
        wr_en |-> !$isunknown(shape));  // R1

    AST_CLOCKED_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!flow_sel && !rd_en) |=> (flow_sel || $stable(rd_data)));  // R5

    AST_FLOW_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (flow_sel && !rd_en) |=> (rd_en || !flow_sel || $stable(rd_data)));  // R7

    AST_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (flow_sel && rd_en) |-> ((rd_data >> (WORD_W >> shape)) == '0));  // R8

    AST_RESET_CLEAR: assert property (@(posedge rd_clk)
        (!rd_rst_n && !flow_sel) |-> (rd_data == '0));  // R10

endmodule

bind aspect_ram aspect_ram_chk #(.WORD_W(WORD_W), .MIN_ABITS(MIN_ABITS)) u_chk (
    .wr_clk(wr_clk), .wr_en(wr_en), .shape(shape), .rd_clk(rd_clk),
    .rd_rst_n(rd_rst_n), .rd_en(rd_en), .flow_sel(flow_sel), .rd_data(rd_data)
);

// File: tb/tb_aspect_ram.sv
`timescale 1ns/1ps
module tb_aspect_ram;

    logic        clk = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic [1:0]  shape = 2'b00;
    logic        rd_rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic        flow_sel = 1'b0;
    logic [8:0]  rd_addr = '0;
    logic [17:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    aspect_ram dut (
        .wr_clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .shape(shape), .rd_clk(clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
        .flow_sel(flow_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int wid(input logic [1:0] m);
        return 18 >> m;
    endfunction

    function automatic int abits(input logic [1:0] m);
        return 6 + m;
    endfunction

    function automatic logic [17:0] pat(input int a, input logic [1:0] m);
        logic [17:0] v;
        v = 18'((a * 13 + int'(m) * 7 + 3) ^ (a << 5) ^ 18'h2A5A5);
        return v & 18'((1 << wid(m)) - 1);
    endfunction

    function automatic logic [8:0] junk_addr(input int a, input logic [1:0] m);
        return 9'(a) | 9'(9'h1FF << abits(m));
    endfunction

    task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] m, input logic [8:0] a,
                            input logic [17:0] d, input bit en);
        @(negedge clk);
        shape = m; wr_addr = a; wr_data = d; wr_en = en;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sync_read(input logic [1:0] m, input logic [8:0] a, output logic [17:0] q);
        @(negedge clk);
        shape = m; flow_sel = 1'b0; rd_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        q = rd_data;
    endtask

    task automatic flow_read(input logic [1:0] m, input logic [8:0] a, output logic [17:0] q);
        @(negedge clk);
        shape = m; flow_sel = 1'b1; rd_addr = a; rd_en = 1'b1;
        #1;
        q = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [17:0] q, old, v;
        repeat (3) @(negedge clk);
        check("R10 reset clears clocked read", rd_data, 18'h0);
        rd_rst_n = 1'b1;

        // R1 R3 R4 R8: sweep every shape, junk on upper address and data lines
        for (int m = 0; m < 4; m++) begin
            for (int a = 0; a < (1 << abits(2'(m))); a++)
                do_write(2'(m), junk_addr(a, 2'(m)),
                         pat(a, 2'(m)) | 18'(18'h3FFFF << wid(2'(m))), 1'b1);
            for (int a = 0; a < (1 << abits(2'(m))); a++) begin
                sync_read(2'(m), junk_addr(a, 2'(m)), q);
                check("R1/R3/R4/R8 clocked sweep", q, pat(a, 2'(m)));
            end
            for (int a = 0; a < (1 << abits(2'(m))); a++) begin
                flow_read(2'(m), junk_addr(a, 2'(m)), q);
                check("R6/R8 flow sweep", q, pat(a, 2'(m)));
            end
        end

        // R11: one 18-bit word seen through the other shapes
        v = 18'h2D3C5;
        do_write(2'b00, 9'd0, v, 1'b1);
        for (int k = 0; k < 9; k++) begin
            flow_read(2'b11, 9'(k), q);
            check("R11 512x2 slice", q, (v >> (2 * k)) & 18'h3);
        end
        flow_read(2'b01, 9'd1, q);
        check("R11 128x9 upper half", q, v >> 9);
        flow_read(2'b10, 9'd1, q);
        check("R11 256x4 second nibble", q, (v >> 4) & 18'hF);

        // R2: write with enable low leaves the word alone
        do_write(2'b00, 9'd5, 18'h11111, 1'b1);
        do_write(2'b00, 9'd5, 18'h22222, 1'b0);
        sync_read(2'b00, 9'd5, q);
        check("R2 no store with wr_en low", q, 18'h11111);

        // R9: same-edge write and clocked read of one address
        do_write(2'b00, 9'd20, 18'h0ABCD, 1'b1);
        @(negedge clk);
        shape = 2'b00; flow_sel = 1'b0;
        wr_addr = 9'd20; wr_data = 18'h31234; wr_en = 1'b1;
        rd_addr = 9'd20; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9 same-edge read returns old word", rd_data, 18'h0ABCD);
        sync_read(2'b00, 9'd20, q);
        check("R9 new word visible afterwards", q, 18'h31234);

        // R5: clocked hold
        do_write(2'b00, 9'd41, 18'h05555, 1'b1);
        sync_read(2'b00, 9'd40, old);
        @(negedge clk);
        rd_addr = 9'd41;
        @(negedge clk);
        check("R5 clocked read holds with rd_en low", rd_data, old);

        // R6: flow-through sees a fresh write
        do_write(2'b00, 9'd30, 18'h01357, 1'b1);
        flow_read(2'b00, 9'd30, q);
        check("R6 flow read before write", q, 18'h01357);
        do_write(2'b00, 9'd30, 18'h2468A, 1'b1);
        #1;
        check("R6 flow read follows write", rd_data, 18'h2468A);

        // R7: flow hold keeps last loaded word
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 9'd31;
        #1;
        check("R7 flow hold after rd_en low", rd_data, 18'h2468A);
        do_write(2'b00, 9'd30, 18'h3F00F, 1'b1);
        #1;
        check("R7 flow hold ignores overwrite", rd_data, 18'h2468A);

        // R10: reset again mid-run
        @(negedge clk);
        flow_sel = 1'b0; rd_rst_n = 1'b0;
        #1;
        check("R10 reset clears read register", rd_data, 18'h0);
        @(negedge clk);
        rd_rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule